// File: doc/BRIEF.md
# Three-Byte Strobed Register Memory

This block is a bus slave that holds three separate 8-bit storage registers. A bus master reaches them through a small control bus. A 2-bit select code picks a register, an active-low strobe validates the access, and a direction line chooses the operation: low means read and high means write. Data enters on its own 8-bit input bus and leaves on a separate 8-bit output bus.

A read is an access with the strobe low and the direction line low. The addressed register then drives the output bus and raises a valid flag. When no register drives the bus, the flag is low and the bus reads as zero. This pair models a released, high-impedance bus.

A write is made by raising the direction line from 0 to 1 while the strobe is low. The addressed register then stores the input byte. The control lines may come from another clock domain, so all control and data inputs pass through a two-stage synchronizer before any decision is taken. Every port effect therefore lags the pins by two clock edges.

Top module: `strobed_byte_store`

## Requirements
- R1: After reset, all three registers hold 0x00.
- R2: Select codes 0, 1 and 2 address registers 0, 1 and 2. Code 3 addresses none: every output enable stays high, every write clock stays low and no register changes.
- R3: While the synchronized strobe is high, every active-low output enable is high and every write clock is low. No register changes, even when the direction line toggles.
- R4: With the strobe low, the direction line low and a valid code, the addressed register's enable bit (bit i of `oe_n_o` for register i) goes low. `rd_data_o` then carries that register and `rd_valid_o` is 1, two clock edges after the pins settle.
- R5: A 0-to-1 transition of the synchronized direction line, while the strobe is low, stores the synchronized input byte into the addressed register. A later read returns it.
- R6: Lowering the strobe while the direction line is already high stores nothing.
- R7: A write to one register leaves the other two unchanged.
- R8: At most one output enable is low at any time. When none is low, `rd_valid_o` is 0 and `rd_data_o` is 0x00, which models a high-impedance bus.
- R9: Bit i of `wclk_o` follows the synchronized direction line while the strobe is low and register i is addressed. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 2 | Register select code |
| strobe_n_i | input | 1 | Active-low access strobe |
| dir_i | input | 1 | Direction: 0 read, 1 write (rising edge stores) |
| wr_data_i | input | 8 | Input data bus |
| rd_data_o | output | 8 | Output data bus, 0x00 when released |
| rd_valid_o | output | 1 | High while a register drives the output bus |
| oe_n_o | output | 3 | Per-register active-low output enable |
| wclk_o | output | 3 | Per-register write clock level |

## Verification
The assertions check the decode rules on every cycle, using the synchronized controls:
- a high strobe or an unused code enables nothing and freezes storage;
- at most one enable is active;
- a released bus reads zero;
- a qualified read always raises the valid flag.

Only the bench scenarios can show what a register actually holds. These cover the values that follow a write edge, that neighbouring registers keep their contents, that a strobe falling under an already-high direction line stores nothing, and the two-edge latency from pins to outputs.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int unsigned SBS_NREG   = 3;
  localparam int unsigned SBS_DW     = 8;
  localparam int unsigned SBS_STAGES = 2;
endpackage

// File: rtl/sbs_sync.sv
module sbs_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sbs_decode.sv
module sbs_decode #(
  parameter int unsigned NREG = 3,
  parameter int unsigned AW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   sel_s,
  input  logic            strobe_n_s,
  input  logic            dir_s,
  output logic [NREG-1:0] oe_n,
  output logic [NREG-1:0] wclk,
  output logic [NREG-1:0] wr_pulse
);
  logic dir_prev_q;
  logic dir_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_prev_q <= 1'b0;
    else        dir_prev_q <= dir_s;
  end

  assign dir_rise = dir_s & ~dir_prev_q;

  for (genvar i = 0; i < NREG; i++) begin : g_line
    logic hit;
    assign hit         = ~strobe_n_s && (sel_s == AW'(i));
    assign oe_n[i]     = ~(hit & ~dir_s);
    assign wclk[i]     = hit & dir_s;
    assign wr_pulse[i] = hit & dir_rise;
  end
endmodule

// File: rtl/sbs_bank.sv
module sbs_bank #(
  parameter int unsigned NREG = 3,
  parameter int unsigned DW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREG-1:0]    wr_pulse,
  input  logic [DW-1:0]      wr_data,
  input  logic [NREG-1:0]    oe_n,
  output logic [NREG*DW-1:0] mem_flat,
  output logic [DW-1:0]      rd_data,
  output logic               rd_valid
);
  logic [DW-1:0] cell_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cell_q[i] <= '0;
      else if (wr_pulse[i]) cell_q[i] <= wr_data;
    end
    assign mem_flat[i*DW +: DW] = cell_q[i];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (!oe_n[i]) rd_data = rd_data | cell_q[i];
    end
  end

  assign rd_valid = ~&oe_n;
endmodule

// File: rtl/strobed_byte_store.sv
module strobed_byte_store
  import sbs_pkg::*;
#(
  parameter int unsigned NREG   = SBS_NREG,
  parameter int unsigned DW     = SBS_DW,
  parameter int unsigned STAGES = SBS_STAGES,
  localparam int unsigned AW    = $clog2(NREG + 1),
  localparam int unsigned SW    = 2 + AW + DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   sel_i,
  input  logic            strobe_n_i,
  input  logic            dir_i,
  input  logic [DW-1:0]   wr_data_i,
  output logic [DW-1:0]   rd_data_o,
  output logic            rd_valid_o,
  output logic [NREG-1:0] oe_n_o,
  output logic [NREG-1:0] wclk_o
);
  localparam logic [SW-1:0] SYNC_RST = {1'b1, {(SW-1){1'b0}}};

  logic [SW-1:0]      raw_bus, sync_bus;
  logic               strobe_n_s, dir_s;
  logic [AW-1:0]      sel_s;
  logic [DW-1:0]      wdata_s;
  logic [NREG-1:0]    wr_pulse;
  logic [NREG*DW-1:0] mem_flat;

  assign raw_bus = {strobe_n_i, dir_i, sel_i, wr_data_i};

  sbs_sync #(.W(SW), .STAGES(STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_bus), .q_o(sync_bus)
  );

  assign {strobe_n_s, dir_s, sel_s, wdata_s} = sync_bus;

  sbs_decode #(.NREG(NREG), .AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .strobe_n_s(strobe_n_s),
    .dir_s(dir_s), .oe_n(oe_n_o), .wclk(wclk_o), .wr_pulse(wr_pulse)
  );

  sbs_bank #(.NREG(NREG), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_data(wdata_s),
    .oe_n(oe_n_o), .mem_flat(mem_flat), .rd_data(rd_data_o),
    .rd_valid(rd_valid_o)
  );
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int unsigned NREG = 3,
  parameter int unsigned DW   = 8,
  parameter int unsigned AW   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               strobe_n_s,
  input logic               dir_s,
  input logic [AW-1:0]      sel_s,
  input logic [NREG-1:0]    oe_n_o,
  input logic [NREG-1:0]    wclk_o,
  input logic [NREG*DW-1:0] mem_flat,
  input logic [DW-1:0]      rd_data_o,
  input logic               rd_valid_o
);
  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_n_s |-> (&oe_n_o && wclk_o == '0));

  assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_n_s |=> $stable(mem_flat));

  assert_nosel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_s >= AW'(NREG)) |-> (&oe_n_o && wclk_o == '0));

  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~oe_n_o));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_o |-> (rd_data_o == '0));

  assert_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n_s && !dir_s && sel_s < AW'(NREG)) |-> rd_valid_o);
endmodule

bind strobed_byte_store sbs_checker #(.NREG(NREG), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe_n_s(strobe_n_s), .dir_s(dir_s),
  .sel_s(sel_s), .oe_n_o(oe_n_o), .wclk_o(wclk_o), .mem_flat(mem_flat),
  .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
);

// File: tb/tb_strobed_byte_store.sv
module tb_strobed_byte_store;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel_i = 2'd0;
  logic       strobe_n_i = 1'b1;
  logic       dir_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       rd_valid_o;
  logic [2:0] oe_n_o;
  logic [2:0] wclk_o;

  always #5 clk = ~clk;

  strobed_byte_store dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .strobe_n_i(strobe_n_i),
    .dir_i(dir_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .oe_n_o(oe_n_o), .wclk_o(wclk_o)
  );

  typedef struct {
    string      req;
    logic [7:0] data;
    logic       vld;
    logic [2:0] oe_n;
    logic [2:0] wclk;
  } exp_t;

  exp_t       sb_q[$];
  int         n_run = 0;
  int         n_fail = 0;
  logic [7:0] model [3];
  bit         done = 0;

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_run++;
      if (rd_data_o !== e.data || rd_valid_o !== e.vld ||
          oe_n_o !== e.oe_n || wclk_o !== e.wclk) begin
        n_fail++;
        $display("FAIL %s: got data=%h vld=%b oe_n=%b wclk=%b exp data=%h vld=%b oe_n=%b wclk=%b",
                 e.req, rd_data_o, rd_valid_o, oe_n_o, wclk_o,
                 e.data, e.vld, e.oe_n, e.wclk);
      end
      // R8: at most one enable low at any sampled point
      n_run++;
      if (!$onehot0(~oe_n_o)) begin
        n_fail++;
        $display("FAIL R8: oe_n=%b exp at most one low", oe_n_o);
      end
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic expect_now(string req, logic [7:0] d, logic v,
                            logic [2:0] oe, logic [2:0] wc);
    exp_t e;
    e.req = req; e.data = d; e.vld = v; e.oe_n = oe; e.wclk = wc;
    sb_q.push_back(e);
    tick(1);
  endtask

  function automatic logic [2:0] onecold(int a);
    return (a < 3) ? ~(3'b001 << a) : 3'b111;
  endfunction

  function automatic logic [2:0] onehot(int a);
    return (a < 3) ? (3'b001 << a) : 3'b000;
  endfunction

  task automatic do_read(string req, int a);
    strobe_n_i = 1; dir_i = 0; sel_i = 2'(a); tick(3);
    strobe_n_i = 0; tick(3);
    if (a < 3) expect_now(req, model[a], 1'b1, onecold(a), 3'b000);
    else       expect_now(req, 8'h00, 1'b0, 3'b111, 3'b000);
    strobe_n_i = 1; tick(3);
  endtask

  task automatic do_write(string req, int a, logic [7:0] d);
    strobe_n_i = 1; dir_i = 0; sel_i = 2'(a); wr_data_i = d; tick(3);
    strobe_n_i = 0; tick(3);
    dir_i = 1; tick(3);
    // R9: write clock of the addressed register follows the direction line
    expect_now({req, "/R9"}, 8'h00, 1'b0, 3'b111, onehot(a));
    dir_i = 0; tick(3);
    strobe_n_i = 1; tick(3);
    if (a < 3) model[a] = d;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, exp completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) model[i] = 8'h00;
    tick(3);
    rst_n = 1;
    tick(2);
    // R1: reset state
    expect_now("R1 idle", 8'h00, 1'b0, 3'b111, 3'b000);
    do_read("R1", 0);
    do_read("R1", 1);
    do_read("R1", 2);
    // R5 / R4: distinct patterns
    do_write("R5", 0, 8'hA5);
    do_read("R4", 0);
    do_write("R5", 1, 8'h3C);
    do_read("R4", 1);
    do_write("R5", 2, 8'hFF);
    do_read("R4", 2);
    // R7: neighbours untouched by a write to register 1
    do_write("R7", 1, 8'h81);
    do_read("R7", 0);
    do_read("R7", 2);
    do_read("R7", 1);
    // R2: code 3 selects nothing, write to it changes nothing
    do_read("R2", 3);
    do_write("R2", 3, 8'h55);
    do_read("R2", 0);
    do_read("R2", 1);
    do_read("R2", 2);
    // R3: strobe high, direction toggles, nothing enabled or stored
    strobe_n_i = 1; sel_i = 2'd0; wr_data_i = 8'h11; dir_i = 0; tick(3);
    dir_i = 1; tick(3);
    expect_now("R3", 8'h00, 1'b0, 3'b111, 3'b000);
    dir_i = 0; tick(3);
    do_read("R3", 0);
    // R6: strobe falls while direction already high
    strobe_n_i = 1; sel_i = 2'd2; wr_data_i = 8'h22; dir_i = 1; tick(3);
    strobe_n_i = 0; tick(3);
    expect_now("R6 wclk", 8'h00, 1'b0, 3'b111, 3'b100);
    strobe_n_i = 1; tick(3);
    dir_i = 0; tick(3);
    do_read("R6", 2);
    // R8: released bus after all accesses
    expect_now("R8 release", 8'h00, 1'b0, 3'b111, 3'b000);
    tick(3);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule